// File: doc/BRIEF.md
# Counted-Enable Interrupt Pending Aggregator

This block gathers a parameterised set of level-sensitive interrupt sources into one request line for a processor. Each source has an enable counter. Every enable pulse raises the counter by one and every disable pulse lowers it by one. A source is enabled only while its counter equals a required count fixed at build time. That count is the number of independent controls, such as mask bits and groups, that must all be open before the source can interrupt. A source is pending when its input is asserted and it is enabled.

The block keeps a running total of pending sources. It updates the total by adding the sources that became pending and subtracting the sources that stopped being pending in the same cycle. The request line is high whenever that total is non-zero.

When the processor acknowledges, the block returns the configured vector code of the lowest-numbered pending source, together with a valid flag. The processor also supplies its 4-bit interrupt mask. An all-ones mask suppresses the answer, and so does having no pending source. Source index 0 is reserved and never pending.

Top module: `intc_pend_agg`

## Requirements
- R1: After reset, `irq_out` and `ack_valid` are low, `ack_vector` is zero, every enable counter is zero and every source is deasserted.
- R2: A source's assertion state follows its level input at the next clock edge, so a rising level asserts it and a falling level deasserts it. A level held high keeps the source asserted with no further effect.
- R3: An enable pulse adds one to the source's counter and a disable pulse subtracts one. Both pulses in the same cycle leave the counter unchanged. An enable at the all-ones counter value is ignored, and so is a disable at zero.
- R4: A source is pending exactly when it is asserted and its counter equals its required count from `REQ_TAB` (bits `[i*CNT_W +: CNT_W]` for source i). A counter above or below that count leaves the source not pending.
- R5: The block keeps a count of pending sources. Several sources may enter or leave pending in one cycle, and the count stays equal to the number of pending sources.
- R6: `irq_out` is high exactly when the pending count is non-zero, and it changes at the same clock edge as the pending state it reflects.
- R7: An `ack_req` sampled at a clock edge sets `ack_valid` high for the following cycle when a source is pending and `cpu_mask` is not 4'hF. `ack_vector` then holds the `VEC_TAB` entry (bits `[i*VEC_W +: VEC_W]`) of the lowest-indexed source that was pending before that edge. While `ack_valid` is low, `ack_vector` is zero.
- R8: An acknowledge with `cpu_mask` equal to 4'hF returns `ack_valid` low.
- R9: An acknowledge while no source is pending returns `ack_valid` low.
- R10: Source 0 is reserved. Its level, enable and disable inputs have no effect, and it never becomes pending or wins an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Level of each interrupt source |
| en_pulse | input | NUM_SRC | One-cycle enable event per source |
| dis_pulse | input | NUM_SRC | One-cycle disable event per source |
| ack_req | input | 1 | Processor acknowledge request |
| cpu_mask | input | 4 | Processor interrupt mask level |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge answer carries a vector |
| ack_vector | output | VEC_W | Vector code of the winning source |

## Verification
On every cycle, the assertions check several properties. The incremental pending total must match the population of the pending flags. The request line must rise only from a zero total and must agree with that total. Each counter must step by exactly one, or stay at its floor. An answer must appear only after a request that carried an open mask, with the vector zeroed when no answer is given. Other behaviour shows only in the bench's scenarios, which a reference model scores. These cover which source wins an acknowledge, whether the required count and the counter saturation are honoured, whether the reserved source stays silent, and whether simultaneous entries and exits from pending keep the line correct.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_UP   = 2'd1,
      ACT_DOWN = 2'd2
   } cnt_act_e;

   localparam logic [3:0] MASK_BLOCK_ALL = 4'hF;

   function automatic cnt_act_e pick_act(input logic up, input logic down);
      cnt_act_e a;
      if (up && !down)      a = ACT_UP;
      else if (down && !up) a = ACT_DOWN;
      else                  a = ACT_HOLD;
      return a;
   endfunction

endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot
   import intc_agg_pkg::*;
#(
   parameter int CNT_W = 3,
   parameter int REQ   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic en,
   input  logic dis,
   output logic pend_d,
   output logic pend_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] REQ_V   = CNT_W'(REQ);

   if (REQ < 1 || REQ > (1 << CNT_W) - 1) begin : g_bad_req
      $error("intc_src_slot: REQ must fit in 1..2**CNT_W-1");
   end

   logic             asrt_q, asrt_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   cnt_act_e         act;

   always_comb begin
      act    = pick_act(en, dis);
      cnt_d  = cnt_q;
      asrt_d = asrt_q;
      if (level && !asrt_q)      asrt_d = 1'b1;
      else if (!level && asrt_q) asrt_d = 1'b0;
      case (act)
         ACT_UP:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
         ACT_DOWN: if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
         default:  cnt_d = cnt_q;
      endcase
      pend_d = asrt_d && (cnt_d == REQ_V);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asrt_q <= 1'b0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         asrt_q <= asrt_d;
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
      end
   end

   // R3
   cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !dis && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R3
   cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && !en && cnt_q == '0) |=> (cnt_q == '0));
   // R3
   cnt_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dis && en) |=> $stable(cnt_q));
   // R2
   pend_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(level));

endmodule

// File: rtl/intc_pend_count.sv
module intc_pend_count #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_d,
   input  logic [NUM_SRC-1:0] pend_q,
   output logic               irq_q
);
   localparam int PC_W = $clog2(NUM_SRC + 1);

   logic [NUM_SRC-1:0] enter, leave;
   logic [PC_W-1:0]    n_enter, n_leave;
   logic [PC_W-1:0]    cnt_q, cnt_d;

   always_comb begin
      enter   = pend_d & ~pend_q;
      leave   = pend_q & ~pend_d;
      n_enter = PC_W'($countones(enter));
      n_leave = PC_W'($countones(leave));
      cnt_d   = cnt_q + n_enter - n_leave;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (cnt_q == '0 && cnt_d != '0) irq_q <= 1'b1;
         else if (cnt_d == '0)           irq_q <= 1'b0;
      end
   end

   // R5
   cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q == PC_W'($countones(pend_q)));
   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> ($past(cnt_q) == '0));
   // R6
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (cnt_q != '0));

endmodule

// File: rtl/intc_ack_sel.sv
module intc_ack_sel
   import intc_agg_pkg::*;
#(
   parameter int                     NUM_SRC = 8,
   parameter int                     VEC_W   = 12,
   parameter logic [NUM_SRC*VEC_W-1:0] VEC_TAB = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_q,
   input  logic               ack_req,
   input  logic [3:0]         cpu_mask,
   output logic               ack_valid,
   output logic [VEC_W-1:0]   ack_vector
);
   logic             hit;
   logic [VEC_W-1:0] sel;

   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            hit = 1'b1;
            sel = VEC_TAB[i*VEC_W +: VEC_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid  <= 1'b0;
         ack_vector <= '0;
      end else if (ack_req && hit && cpu_mask != MASK_BLOCK_ALL) begin
         ack_valid  <= 1'b1;
         ack_vector <= sel;
      end else begin
         ack_valid  <= 1'b0;
         ack_vector <= '0;
      end
   end

   // R8
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(cpu_mask) != MASK_BLOCK_ALL));
   // R7
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(ack_req));
   // R9
   ack_need_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(pend_q) != '0));
   // R7
   vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_valid |-> (ack_vector == '0));

endmodule

// File: rtl/intc_pend_agg.sv
module intc_pend_agg #(
   parameter int                       NUM_SRC = 8,
   parameter int                       CNT_W   = 3,
   parameter int                       VEC_W   = 12,
   parameter logic [NUM_SRC*CNT_W-1:0] REQ_TAB =
      {3'd2, 3'd1, 3'd3, 3'd1, 3'd2, 3'd1, 3'd1, 3'd0},
   parameter logic [NUM_SRC*VEC_W-1:0] VEC_TAB =
      {12'h2E0, 12'h2C0, 12'h2A0, 12'h280, 12'h260, 12'h240, 12'h220, 12'h200}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_level,
   input  logic [NUM_SRC-1:0] en_pulse,
   input  logic [NUM_SRC-1:0] dis_pulse,
   input  logic               ack_req,
   input  logic [3:0]         cpu_mask,
   output logic               irq_out,
   output logic               ack_valid,
   output logic [VEC_W-1:0]   ack_vector
);
   if (NUM_SRC < 2) begin : g_bad_num
      $error("intc_pend_agg: NUM_SRC must be at least 2");
   end
   if (CNT_W < 1 || VEC_W < 1) begin : g_bad_width
      $error("intc_pend_agg: CNT_W and VEC_W must be positive");
   end

   logic [NUM_SRC-1:0] pend_d, pend_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == 0) begin : g_rsv
         logic unused_rsv;
         assign unused_rsv = src_level[i] ^ en_pulse[i] ^ dis_pulse[i];
         assign pend_d[i]  = 1'b0;
         assign pend_q[i]  = 1'b0;
      end else begin : g_live
         intc_src_slot #(
            .CNT_W (CNT_W),
            .REQ   (int'(REQ_TAB[i*CNT_W +: CNT_W]))
         ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (src_level[i]),
            .en     (en_pulse[i]),
            .dis    (dis_pulse[i]),
            .pend_d (pend_d[i]),
            .pend_q (pend_q[i])
         );
      end
   end

   intc_pend_count #(
      .NUM_SRC (NUM_SRC)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_d (pend_d),
      .pend_q (pend_q),
      .irq_q  (irq_out)
   );

   intc_ack_sel #(
      .NUM_SRC (NUM_SRC),
      .VEC_W   (VEC_W),
      .VEC_TAB (VEC_TAB)
   ) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_q     (pend_q),
      .ack_req    (ack_req),
      .cpu_mask   (cpu_mask),
      .ack_valid  (ack_valid),
      .ack_vector (ack_vector)
   );

   // R10
   rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (ack_vector != VEC_TAB[VEC_W-1:0]));

endmodule

// File: tb/sim_intc_pend_agg.sv
module sim_intc_pend_agg;
   localparam int N  = 8;
   localparam int CW = 3;
   localparam int VW = 12;
   localparam logic [N*CW-1:0] REQ_T =
      {3'd2, 3'd1, 3'd3, 3'd1, 3'd2, 3'd1, 3'd1, 3'd0};
   localparam logic [N*VW-1:0] VEC_T =
      {12'h2E0, 12'h2C0, 12'h2A0, 12'h280, 12'h260, 12'h240, 12'h220, 12'h200};
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_level = '0, en_pulse = '0, dis_pulse = '0;
   logic          ack_req = 1'b0;
   logic [3:0]    cpu_mask = 4'h0;
   logic          irq_out, ack_valid;
   logic [VW-1:0] ack_vector;

   always #10 clk = ~clk;

   intc_pend_agg #(.NUM_SRC(N), .CNT_W(CW), .VEC_W(VW),
                   .REQ_TAB(REQ_T), .VEC_TAB(VEC_T)) u0 (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_pulse(en_pulse),
      .dis_pulse(dis_pulse), .ack_req(ack_req), .cpu_mask(cpu_mask),
      .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector));

   typedef struct {
      logic          irq;
      logic          vld;
      logic [VW-1:0] vec;
      string         tag;
   } exp_t;

   exp_t   sb[$];
   int     total = 0;
   int     bad = 0;
   logic [N-1:0] lvl = '0;
   logic   m_asrt [N];
   int     m_cnt  [N];

   function automatic logic m_pend(int i);
      return (i != 0) && m_asrt[i] && (m_cnt[i] == int'(REQ_T[i*CW +: CW]));
   endfunction

   task automatic step(input logic [N-1:0] en, input logic [N-1:0] dis,
                       input logic ack, input logic [3:0] msk, input string tag);
      exp_t e;
      @(negedge clk);
      src_level = lvl; en_pulse = en; dis_pulse = dis;
      ack_req = ack; cpu_mask = msk;
      e.vld = 1'b0; e.vec = '0; e.tag = tag;
      if (ack && msk != 4'hF) begin
         for (int i = N - 1; i >= 0; i--)
            if (m_pend(i)) begin e.vld = 1'b1; e.vec = VEC_T[i*VW +: VW]; end
      end
      for (int i = 0; i < N; i++) begin
         m_asrt[i] = lvl[i];
         if (en[i] && !dis[i] && m_cnt[i] < CMAX) m_cnt[i]++;
         else if (dis[i] && !en[i] && m_cnt[i] > 0) m_cnt[i]--;
      end
      e.irq = 1'b0;
      for (int i = 0; i < N; i++) if (m_pend(i)) e.irq = 1'b1;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      step('0, '0, 1'b0, 4'h0, tag);
   endtask

   task automatic ack(input logic [3:0] msk, input string tag);
      step('0, '0, 1'b1, msk, tag);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: compares one scoreboard item per clock edge, in the high phase
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            total++;
            if (irq_out !== e.irq) begin
               bad++;
               $display("FAIL %s irq_out actual=%b expected=%b", e.tag, irq_out, e.irq);
            end
            total++;
            if (ack_valid !== e.vld) begin
               bad++;
               $display("FAIL %s ack_valid actual=%b expected=%b", e.tag, ack_valid, e.vld);
            end
            total++;
            if (ack_vector !== e.vec) begin
               bad++;
               $display("FAIL %s ack_vector actual=%h expected=%h", e.tag, ack_vector, e.vec);
            end
         end
      end
   end

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_asrt[i] = 1'b0; m_cnt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      idle("R1");
      ack(4'h0, "R1");
      // R4: asserted but counter below required count
      lvl[1] = 1'b1; idle("R4");
      step(8'h02, '0, 1'b0, 4'h0, "R4");
      // R7 / R8 acknowledge of source 1
      ack(4'h0, "R7");
      ack(4'hF, "R8");
      // R4: source 3 needs two enables
      lvl[3] = 1'b1; step(8'h08, '0, 1'b0, 4'h0, "R4");
      step(8'h08, '0, 1'b0, 4'h0, "R4");
      ack(4'h5, "R7");
      // R5: source 1 leaves, source 3 keeps the line high
      lvl[1] = 1'b0; idle("R5");
      ack(4'h3, "R7");
      // R4 / R6: overshoot disables source 3, line drops
      step(8'h08, '0, 1'b0, 4'h0, "R6");
      // R3: simultaneous enable and disable hold the counter
      step(8'h08, 8'h08, 1'b0, 4'h0, "R3");
      step('0, 8'h08, 1'b0, 4'h0, "R3");
      // R3: disable at zero is ignored
      step('0, 8'h04, 1'b0, 4'h0, "R3");
      lvl[2] = 1'b1; step(8'h04, '0, 1'b0, 4'h0, "R3");
      ack(4'h0, "R7");
      // R3: enable saturates at the top
      for (int k = 0; k < 9; k++) step(8'h80, '0, 1'b0, 4'h0, "R3");
      lvl[7] = 1'b1;
      for (int k = 0; k < 5; k++) step('0, 8'h80, 1'b0, 4'h0, "R3");
      // R10: reserved source has no effect
      lvl[0] = 1'b1; step(8'h01, '0, 1'b0, 4'h0, "R10");
      step(8'h01, '0, 1'b1, 4'h0, "R10");
      lvl[2] = 1'b0; lvl[3] = 1'b0; lvl[7] = 1'b0; idle("R10");
      ack(4'h0, "R10");
      // R5 / R6: many sources leave and enter in one cycle
      step(8'h70, '0, 1'b0, 4'h0, "R5");
      step(8'h20, '0, 1'b0, 4'h0, "R5");
      step(8'h20, '0, 1'b0, 4'h0, "R5");
      lvl = 8'hFF; idle("R5");
      ack(4'h0, "R7");
      lvl = 8'h00; idle("R6");
      ack(4'h0, "R9");
      lvl = 8'hFE; idle("R5");
      // R2: level held high
      for (int k = 0; k < 4; k++) ack(4'(k), "R2");
      lvl = 8'h10; idle("R2");
      ack(4'h1, "R7");
      lvl = 8'h00; idle("R2");
      ack(4'h0, "R9");
      idle("R9");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule